// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block fronts a synchronous single-port memory of 32-bit words. A 16-bit start address is captured when one of two active-low address strobes is sampled low on a rising clock edge. One strobe belongs to the processor and the other to an external cache controller. After the capture, the two least significant address bits are stepped through a four-beat group. The step happens only on edges where the active-low advance input is low. A static order input picks the stepping pattern: high gives interleaved order, where the low bits are the start value XOR the beat count, and low gives linear order, where they are the start value plus the beat count, wrapping modulo four.

Three chip enables are sampled on the clock edge: `ce0_n` must be low, `ce1` high and `ce2_n` low for the device to count as selected. Writes are synchronous. They are steered to the four byte lanes by an active-low global write and an active-low byte-write enable, each lane having its own active-low select. Reads are flow-through: the word at the current burst address appears in the same cycle. An asynchronous active-low output enable gates the read port. A sleep input freezes the sequencer, blocks writes and turns the read drive off, but the stored contents are kept. The array is modelled with a reduced depth: the low `MEM_AW` address bits index it.

Top module: `burst_sram_seq`

## Requirements
- R1: After reset the sequencer is inactive, `burst_addr_o` is 0 and `rdrive_o` is 0.
- R2: With the device selected and sleep low, a low `proc_stb_n` loads `addr_i`, resets the beat count to 0 and makes the sequencer active on that edge.
- R3: A low `proc_stb_n` while the device is deselected is ignored: the address and the active state keep their values.
- R4: When `ctrl_stb_n` is low and `proc_stb_n` is high, the chip enables are re-evaluated. If selected, `addr_i` is loaded. If deselected, the sequencer goes inactive and the read drive turns off.
- R5: When both strobes are low together, the processor strobe rule alone applies. A deselected cycle therefore leaves an active sequencer active.
- R6: The beat count advances by one only on edges where `adv_n` is low, the sequencer is active and no strobe is low; otherwise the address holds. Bits 15:2 never change within a burst.
- R7: With `order_i`=1, bits 1:0 follow start XOR beat; for example, start 1 gives 1,0,3,2 and then wraps to 1.
- R8: With `order_i`=0, bits 1:0 follow (start + beat) mod 4; for example, start 2 gives 2,3,0,1.
- R9: A write occurs on an edge where the sequencer is active, sleep is low and both strobes are high. It goes to the current burst address. `wr_all_n`=0 writes all four lanes. Otherwise lane i (bits 8i+7:8i) is written only when `wr_byte_n`=0 and `lane_sel_n[i]`=0. Write inputs on strobe edges are ignored.
- R10: `rdrive_o` is high only while `oe_n` is low, the sequencer is active and sleep is low. It follows `oe_n` without waiting for a clock edge. When `rdrive_o` is low, `rdata_o` is 0.
- R11: While `sleep_i` is high, strobes and advance are ignored, no write occurs and the read drive is off. The stored words survive and are read back after sleep ends.
- R12: While driven, `rdata_o` equals the stored word at the current burst address in the same cycle as that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Start address captured by a strobe |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| order_i | input | 1 | 1 interleaved, 0 linear |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | DATA_W/LANE_W | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, 0 when not driven |
| rdrive_o | output | 1 | Read port drive enable |
| burst_addr_o | output | ADDR_W | Current burst address |

## Verification
The bench builds the block with its defaults: 16-bit addresses, 32-bit words in 8-bit lanes, a 256-word array and pin-selected order. Because `order_i` chooses the order at run time, both the interleaved and the linear walks can be reached in one build. Because only 8 of the 16 address bits index the array, random start addresses alias heavily. Read-after-write through different bursts therefore happens often, so partial lane writes and sleep retention can be checked against earlier data.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_PROC = 2'd1,
      OP_CTRL = 2'd2,
      OP_STEP = 2'd3
   } seq_op_e;

   localparam int ORDER_LINEAR_ONLY     = 0;
   localparam int ORDER_INTERLEAVE_ONLY = 1;
   localparam int ORDER_PIN_SELECT      = 2;

endpackage

// File: rtl/bsq_addr_ctrl.sv
module bsq_addr_ctrl
   import bsq_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int BURST_BITS = 2,
   parameter int ORDER_MODE = ORDER_PIN_SELECT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              proc_stb_n,
   input  logic              ctrl_stb_n,
   input  logic              adv_n,
   input  logic              chip_sel,
   input  logic              sleep_i,
   input  logic              order_i,
   output logic [ADDR_W-1:0] cur_addr_o,
   output logic              active_o
);

   localparam int HI_W = ADDR_W - BURST_BITS;
   localparam logic [BURST_BITS-1:0] BEAT_ONE = BURST_BITS'(1);

   logic [HI_W-1:0]       hi_q;
   logic [BURST_BITS-1:0] start_q;
   logic [BURST_BITS-1:0] beat_q;
   logic [BURST_BITS-1:0] offs;
   logic                  active_q;
   seq_op_e               op;

   // strobe arbitration: processor strobe first, deselected processor load dropped
   always_comb begin
      op = OP_IDLE;
      if (!sleep_i) begin
         if (!proc_stb_n) begin
            op = chip_sel ? OP_PROC : OP_IDLE;
         end else if (!ctrl_stb_n) begin
            op = OP_CTRL;
         end else if (active_q && !adv_n) begin
            op = OP_STEP;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q     <= '0;
         start_q  <= '0;
         beat_q   <= '0;
         active_q <= 1'b0;
      end else begin
         unique case (op)
            OP_PROC: begin
               hi_q     <= addr_i[ADDR_W-1:BURST_BITS];
               start_q  <= addr_i[BURST_BITS-1:0];
               beat_q   <= '0;
               active_q <= 1'b1;
            end
            OP_CTRL: begin
               active_q <= chip_sel;
               if (chip_sel) begin
                  hi_q    <= addr_i[ADDR_W-1:BURST_BITS];
                  start_q <= addr_i[BURST_BITS-1:0];
                  beat_q  <= '0;
               end
            end
            OP_STEP: beat_q <= beat_q + BEAT_ONE;
            default: ;
         endcase
      end
   end

   generate
      if (ORDER_MODE == ORDER_LINEAR_ONLY) begin : g_lin
         assign offs = start_q + beat_q;
      end else if (ORDER_MODE == ORDER_INTERLEAVE_ONLY) begin : g_ilv
         assign offs = start_q ^ beat_q;
      end else begin : g_pin
         assign offs = order_i ? (start_q ^ beat_q) : (start_q + beat_q);
      end
   endgenerate

   assign cur_addr_o = {hi_q, offs};
   assign active_o   = active_q;

   // R2: accepted processor strobe loads the upper address and activates
   p_proc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && !proc_stb_n && chip_sel) |=>
         (active_o && cur_addr_o[ADDR_W-1:BURST_BITS] == $past(addr_i[ADDR_W-1:BURST_BITS])));

   // R3 and R5: deselected processor strobe changes nothing
   p_proc_desel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && !proc_stb_n && !chip_sel) |=>
         ($stable(active_o) && $stable(cur_addr_o[ADDR_W-1:BURST_BITS])));

   // R4: deselected controller strobe ends the burst
   p_ctrl_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && proc_stb_n && !ctrl_stb_n && !chip_sel) |=> !active_o);

   // R6: upper bits fixed whenever nothing is loaded
   p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i || (proc_stb_n && ctrl_stb_n)) |=>
         $stable(cur_addr_o[ADDR_W-1:BURST_BITS]));

   // R6: no advance, no strobe, same order -> whole address holds
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_stb_n && ctrl_stb_n && adv_n) |=>
         ($stable(order_i) -> $stable(cur_addr_o)));

   // R11: sleep freezes the active state
   p_sleep_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> $stable(active_o));

endmodule

// File: rtl/bsq_wr_decode.sv
module bsq_wr_decode #(
   parameter int LANES = 4
) (
   input  logic             allow_i,
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_sel_n,
   output logic [LANES-1:0] lane_we_o
);

   genvar gl;
   generate
      for (gl = 0; gl < LANES; gl++) begin : g_lane
         assign lane_we_o[gl] = allow_i &&
                                (!wr_all_n || (!wr_byte_n && !lane_sel_n[gl]));
      end
   endgenerate

endmodule

// File: rtl/bsq_array.sv
module bsq_array #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   parameter int MEM_AW = 8
) (
   input  logic                     clk,
   input  logic [MEM_AW-1:0]        addr_i,
   input  logic [DATA_W/LANE_W-1:0] lane_we_i,
   input  logic [DATA_W-1:0]        wdata_i,
   output logic [DATA_W-1:0]        rword_o
);

   localparam int LANES = DATA_W / LANE_W;
   localparam int DEPTH = 1 << MEM_AW;

   genvar gl;
   generate
      for (gl = 0; gl < LANES; gl++) begin : g_lane
         logic [LANE_W-1:0] store [DEPTH];

         always_ff @(posedge clk) begin
            if (lane_we_i[gl]) begin
               store[addr_i] <= wdata_i[gl*LANE_W +: LANE_W];
            end
         end

         assign rword_o[gl*LANE_W +: LANE_W] = store[addr_i];
      end
   endgenerate

endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
   import bsq_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int LANE_W     = 8,
   parameter int BURST_BITS = 2,
   parameter int MEM_AW     = 8,
   parameter int ORDER_MODE = ORDER_PIN_SELECT
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic                     proc_stb_n,
   input  logic                     ctrl_stb_n,
   input  logic                     adv_n,
   input  logic                     ce0_n,
   input  logic                     ce1,
   input  logic                     ce2_n,
   input  logic                     order_i,
   input  logic                     wr_all_n,
   input  logic                     wr_byte_n,
   input  logic [DATA_W/LANE_W-1:0] lane_sel_n,
   input  logic                     oe_n,
   input  logic                     sleep_i,
   input  logic [DATA_W-1:0]        wdata_i,
   output logic [DATA_W-1:0]        rdata_o,
   output logic                     rdrive_o,
   output logic [ADDR_W-1:0]        burst_addr_o
);

   localparam int LANES = DATA_W / LANE_W;

   generate
      if (DATA_W % LANE_W != 0) begin : g_bad_lane
         $error("DATA_W must be a whole number of lanes");
      end
      if (MEM_AW > ADDR_W || BURST_BITS >= MEM_AW || BURST_BITS < 1) begin : g_bad_addr
         $error("address widths inconsistent");
      end
      if (ORDER_MODE < ORDER_LINEAR_ONLY || ORDER_MODE > ORDER_PIN_SELECT) begin : g_bad_order
         $error("ORDER_MODE out of range");
      end
   endgenerate

   logic              chip_sel;
   logic              active;
   logic              wr_allow;
   logic [LANES-1:0]  lane_we;
   logic [DATA_W-1:0] rword;

   assign chip_sel = !ce0_n && ce1 && !ce2_n;

   bsq_addr_ctrl #(
      .ADDR_W    (ADDR_W),
      .BURST_BITS(BURST_BITS),
      .ORDER_MODE(ORDER_MODE)
   ) u_actl (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (addr_i),
      .proc_stb_n(proc_stb_n),
      .ctrl_stb_n(ctrl_stb_n),
      .adv_n     (adv_n),
      .chip_sel  (chip_sel),
      .sleep_i   (sleep_i),
      .order_i   (order_i),
      .cur_addr_o(burst_addr_o),
      .active_o  (active)
   );

   assign wr_allow = active && !sleep_i && proc_stb_n && ctrl_stb_n;

   bsq_wr_decode #(.LANES(LANES)) u_wdec (
      .allow_i   (wr_allow),
      .wr_all_n  (wr_all_n),
      .wr_byte_n (wr_byte_n),
      .lane_sel_n(lane_sel_n),
      .lane_we_o (lane_we)
   );

   bsq_array #(
      .DATA_W(DATA_W),
      .LANE_W(LANE_W),
      .MEM_AW(MEM_AW)
   ) u_mem (
      .clk      (clk),
      .addr_i   (burst_addr_o[MEM_AW-1:0]),
      .lane_we_i(lane_we),
      .wdata_i  (wdata_i),
      .rword_o  (rword)
   );

   assign rdrive_o = !oe_n && active && !sleep_i;
   assign rdata_o  = rdrive_o ? rword : '0;

   // R9: no lane is written on a strobe edge or during sleep
   p_no_wr_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_stb_n || !ctrl_stb_n || sleep_i) |-> (lane_we == '0));

   // R10: output enable high keeps the read port quiet
   p_oe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!rdrive_o && rdata_o == '0));

   // R11: sleep keeps the read port quiet
   p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> !rdrive_o);

endmodule

// File: tb/burst_sram_seq_bench.sv
`timescale 1ns/1ps
module burst_sram_seq_bench;

   localparam int AW = 16;
   localparam int DW = 32;
   localparam int NL = 4;
   localparam int MA = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, adv_n = 1'b1;
   logic          ce0_n = 1'b0, ce1 = 1'b1, ce2_n = 1'b0;
   logic          order_i = 1'b1;
   logic          wr_all_n = 1'b1, wr_byte_n = 1'b1;
   logic [NL-1:0] lane_sel_n = '1;
   logic          oe_n = 1'b0, sleep_i = 1'b0;
   logic [DW-1:0] wdata_i = '0;
   logic [DW-1:0] rdata_o;
   logic          rdrive_o;
   logic [AW-1:0] burst_addr_o;

   int nvec = 0;
   int nfail = 0;
   bit finished = 0;

   // reference state
   logic          m_active = 1'b0;
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_beat = '0;
   logic [DW-1:0] m_mem [1<<MA];
   logic [NL-1:0] m_known [1<<MA];

   always #2.5 clk = ~clk;

   burst_sram_seq u_burst_sram_seq (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
      .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
      .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .order_i(order_i),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
      .oe_n(oe_n), .sleep_i(sleep_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .rdrive_o(rdrive_o), .burst_addr_o(burst_addr_o)
   );

   function automatic logic [AW-1:0] exp_addr();
      logic [1:0] lo;
      lo = order_i ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
      return {m_base[AW-1:2], lo};
   endfunction

   function automatic logic exp_drive();
      return !oe_n && m_active && !sleep_i;
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      logic [DW-1:0] mask;
      logic [MA-1:0] idx;
      chk({tag, " addr"}, DW'(burst_addr_o), DW'(exp_addr()));
      chk({tag, " drive R10"}, DW'(rdrive_o), DW'(exp_drive()));
      if (exp_drive()) begin
         idx = exp_addr()[MA-1:0];
         for (int l = 0; l < NL; l++) mask[l*8 +: 8] = {8{m_known[idx][l]}};
         chk({tag, " rdata R12"}, rdata_o & mask, m_mem[idx] & mask);
      end else begin
         chk({tag, " rdata idle R10"}, rdata_o, '0);
      end
   endtask

   task automatic model_edge();
      logic sel;
      logic [MA-1:0] idx;
      sel = !ce0_n && ce1 && !ce2_n;
      if (m_active && !sleep_i && proc_stb_n && ctrl_stb_n) begin
         idx = exp_addr()[MA-1:0];
         for (int l = 0; l < NL; l++) begin
            if (!wr_all_n || (!wr_byte_n && !lane_sel_n[l])) begin
               m_mem[idx][l*8 +: 8] = wdata_i[l*8 +: 8];
               m_known[idx][l] = 1'b1;
            end
         end
      end
      if (!sleep_i) begin
         if (!proc_stb_n) begin
            if (sel) begin m_base = addr_i; m_beat = 0; m_active = 1'b1; end
         end else if (!ctrl_stb_n) begin
            m_active = sel;
            if (sel) begin m_base = addr_i; m_beat = 0; end
         end else if (m_active && !adv_n) begin
            m_beat = m_beat + 2'd1;
         end
      end
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      model_edge();
      #1;
      check_all(tag);
      @(negedge clk);
   endtask

   task automatic idle_in();
      proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1;
      wr_all_n = 1; wr_byte_n = 1; lane_sel_n = '1;
      sleep_i = 0; oe_n = 0; ce0_n = 0; ce1 = 1; ce2_n = 0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < (1 << MA); i++) m_known[i] = '0;
      idle_in();
      repeat (3) @(negedge clk);
      #1 check_all("R1 in reset");
      rst_n = 1;
      @(negedge clk);
      check_all("R1 after reset");

      // R2 processor load, R6 hold
      addr_i = 16'h1235; order_i = 1; proc_stb_n = 0;
      tick("R2 load");
      proc_stb_n = 1;
      tick("R6 hold");
      tick("R6 hold");
      // R7 interleaved walk 1,0,3,2,1
      adv_n = 0;
      repeat (5) tick("R7 interleave");
      adv_n = 1;

      // R8 linear walk via controller strobe, 2,3,0,1,2
      addr_i = 16'hABC6; order_i = 0; ctrl_stb_n = 0;
      tick("R4 ctrl load");
      ctrl_stb_n = 1; adv_n = 0;
      repeat (5) tick("R8 linear");
      adv_n = 1;

      // R9 global writes, strobe-edge write ignored
      addr_i = 16'h0040; proc_stb_n = 0; wr_all_n = 0; wdata_i = 32'hDEAD_BEEF;
      tick("R9 strobe write ignored");
      proc_stb_n = 1; adv_n = 0;
      for (int b = 0; b < 4; b++) begin
         wdata_i = 32'h1111_1111 * (b + 1);
         tick("R9 global write");
      end
      wr_all_n = 1;
      // byte lanes 0 and 2, then byte enable off
      wr_byte_n = 0; lane_sel_n = 4'b1010; wdata_i = 32'hA5A5_A5A5;
      tick("R9 lane write");
      wr_byte_n = 1; lane_sel_n = 4'b0000; wdata_i = 32'h0F0F_0F0F;
      tick("R9 byte enable off");
      adv_n = 1;
      // read back
      addr_i = 16'h0040; proc_stb_n = 0;
      tick("R12 reload");
      proc_stb_n = 1; adv_n = 0;
      repeat (4) tick("R12 readback");
      adv_n = 1;

      // R3 deselected processor strobe
      addr_i = 16'h7777; ce1 = 0; proc_stb_n = 0;
      tick("R3 desel proc");
      // R5 both strobes deselected: active stays
      ctrl_stb_n = 0;
      tick("R5 both strobes");
      proc_stb_n = 1;
      // R4 controller deselect ends burst
      tick("R4 ctrl desel");
      ctrl_stb_n = 1; ce1 = 1;
      tick("R4 inactive");

      // R11 sleep
      addr_i = 16'h0041; proc_stb_n = 0;
      tick("R11 setup");
      proc_stb_n = 1; sleep_i = 1; wr_all_n = 0; wdata_i = 32'h0BAD_0BAD;
      tick("R11 sleep write blocked");
      addr_i = 16'h0300; proc_stb_n = 0; adv_n = 0;
      tick("R11 sleep strobe ignored");
      proc_stb_n = 1; wr_all_n = 1; adv_n = 1; sleep_i = 0;
      tick("R11 wake readback");

      // R10 asynchronous output enable
      oe_n = 1; #1 chk("R10 oe async off", DW'(rdrive_o), 0);
      chk("R10 oe data zero", rdata_o, '0);
      oe_n = 0; #1 chk("R10 oe async on", DW'(rdrive_o), 1);
      @(negedge clk);

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         proc_stb_n = ($urandom % 10) != 0;
         ctrl_stb_n = ($urandom % 12) != 0;
         adv_n      = ($urandom % 5) < 2;
         sleep_i    = ($urandom % 30) == 0;
         ce0_n      = ($urandom % 16) == 0;
         ce1        = ($urandom % 16) != 0;
         ce2_n      = ($urandom % 16) == 0;
         wr_all_n   = ($urandom % 8) != 0;
         wr_byte_n  = ($urandom % 3) != 0;
         lane_sel_n = NL'($urandom);
         oe_n       = ($urandom % 5) == 0;
         addr_i     = AW'($urandom);
         wdata_i    = $urandom;
         if (!proc_stb_n || !ctrl_stb_n) order_i = $urandom % 2;
         tick("R6 R9 R12 random");
      end

      summary();
   end

endmodule